// File: doc/BRIEF.md
# CPU Clock Divider Path

This block makes the processor clock from two slow source waveforms: a crystal reference and a system PLL output. Both sources are level signals that are already sampled into the fast block clock domain. A source selector feeds a divider. The divider runs at a ratio of 1, 2 or 3, or at twice a 9-bit programmable value. An output selector then drives either the divided waveform or the raw crystal level onto `cpu_clk_o`. The output is a registered level in the fast domain that toggles at the chosen rate.

Software controls the block through two 32-bit registers on a plain write/read port, with no handshake. A write to a mapped address lands on the next clock edge, and a read returns data combinationally for the address presented. Every bit of a mapped register reads back exactly as written. The divider takes a new source, ratio or divisor only at the end of its current output period, so a full period always finishes before the new setting starts. The output selector acts at once, which lets software park the core on the crystal while the PLL relocks.

Top module: `cpuclk_gen`

## Requirements
- R1: After reset both registers read 0, and the output follows the crystal. While reset is held, `cpu_clk_o` is 0.
- R2: The divisor register at address 0x00 holds the 9-bit value N in bits 28:20. The control register at address 0x40 holds the source bit (bit 0), the ratio code (bits 3:2) and the output-select bit (bit 7). All 32 bits of both registers read back exactly as written.
- R3: When the output-select bit is 0, `cpu_clk_o` equals the crystal level of the previous clock cycle.
- R4: With ratio code 0 and the output-select bit set, `cpu_clk_o` equals the selected source level delayed by two clock cycles.
- R5: Ratio code 1 gives an output that is high for one source period and low for the next.
- R6: Ratio code 2 gives an output that is high for one source period and low for two.
- R7: Ratio code 3 with N > 0 gives an output that is high for N source periods and low for N, so it divides by 2×N with 50% duty.
- R8: Ratio code 3 with N = 0 holds the divided output low. A nonzero N leaves this state at the next source rising edge.
- R9: Source bit 0 clocks the divider from the crystal, and source bit 1 clocks it from the PLL.
- R10: A change of source, ratio code or N takes effect only at the source rising edge that ends the current output period. No shortened or partial period appears.
- R11: A write to any address other than 0x00 or 0x40 changes no register, and such an address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xtal_i | input | 1 | Crystal reference level, sampled in clk_i domain |
| pll_i | input | 1 | System PLL level, sampled in clk_i domain |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| cpu_clk_o | output | 1 | Generated processor clock level |

## Verification
Suppose the period counter or the committed settings go wrong. The high and low run lengths at `cpu_clk_o`, counted in source periods, then differ from the programmed ratio within one output period. A late or early commit shows up as a run that is too short or too long at the first boundary after the write. A source-select fault shows up as output edges that line up with the wrong source. A hold-mode fault shows up as a high sample within one source period. Register faults show up at once on read-back.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int CC_DATA_W  = 32;
  localparam int CC_ADDR_W  = 8;
  localparam int CC_N_W     = 9;
  localparam int CC_N_LSB   = 20;
  localparam int CC_SEL_LSB = 2;
  localparam int CC_SRC_BIT = 0;
  localparam int CC_OUT_BIT = 7;
  localparam int CC_NREG    = 2;
  localparam logic [CC_ADDR_W-1:0] CC_DIVN_ADDR = 8'h00;
  localparam logic [CC_ADDR_W-1:0] CC_CTRL_ADDR = 8'h40;

  // ratio code order is decoded by the divider: keep the values
  typedef enum logic [1:0] {
    RATIO_1  = 2'd0,
    RATIO_2  = 2'd1,
    RATIO_3  = 2'd2,
    RATIO_2N = 2'd3
  } ratio_e;
endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W = CC_ADDR_W,
  parameter int DATA_W = CC_DATA_W,
  parameter int N_W    = CC_N_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_W-1:0]    div_n_o,
  output ratio_e            ratio_o,
  output logic              src_o,
  output logic              out_sel_o
);
  localparam int NREG = CC_NREG;

  function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
    slot_addr = (idx == 0) ? ADDR_W'(CC_DIVN_ADDR) : ADDR_W'(CC_CTRL_ADDR);
  endfunction

  logic [NREG-1:0][DATA_W-1:0] regs_w;
  logic [NREG-1:0]             hit_w;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
    logic [DATA_W-1:0] q;
    assign hit_w[gi] = (addr_i == slot_addr(gi));
    always_ff @(posedge clk_i) begin
      if (!rst_ni)               q <= '0;
      else if (wr_i && hit_w[gi]) q <= wdata_i;
    end
    assign regs_w[gi] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_w[i]) rdata_o = regs_w[i];
    end
  end

  assign div_n_o   = regs_w[0][CC_N_LSB +: N_W];
  assign ratio_o   = ratio_e'(regs_w[1][CC_SEL_LSB +: 2]);
  assign src_o     = regs_w[1][CC_SRC_BIT];
  assign out_sel_o = regs_w[1][CC_OUT_BIT];

  // R2: a mapped write is held verbatim
  p_write_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_w[1]) |=> (regs_w[1] == $past(wdata_i)));

  // R11: unmapped writes leave both registers alone
  p_unmapped_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (hit_w == '0)) |=> $stable(regs_w));
endmodule

// File: rtl/cpuclk_div.sv
module cpuclk_div
  import cpuclk_pkg::*;
#(
  parameter int N_W = CC_N_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           xtal_i,
  input  logic           pll_i,
  input  logic           stg_src_i,
  input  ratio_e         stg_ratio_i,
  input  logic [N_W-1:0] stg_n_i,
  output logic           lvl_o
);
  localparam int CNT_W = N_W + 1;

  function automatic logic [CNT_W-1:0] last_of(input ratio_e r, input logic [N_W-1:0] n);
    case (r)
      RATIO_1: last_of = '0;
      RATIO_2: last_of = CNT_W'(1);
      RATIO_3: last_of = CNT_W'(2);
      default: last_of = (n == '0) ? '0 : ({n, 1'b0} - CNT_W'(1));
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] high_of(input ratio_e r, input logic [N_W-1:0] n);
    high_of = (r == RATIO_2N) ? {1'b0, n} : CNT_W'(1);
  endfunction

  function automatic logic is_hold(input ratio_e r, input logic [N_W-1:0] n);
    is_hold = (r == RATIO_2N) && (n == '0);
  endfunction

  logic             x_prev_q, p_prev_q;
  logic             act_src_q;
  ratio_e           act_ratio_q;
  logic [N_W-1:0]   act_n_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  logic             rise_w, wrap_w, cur_lvl_w, stg_lvl_w;
  logic [CNT_W-1:0] cnt_inc_w;

  always_comb begin
    rise_w    = act_src_q ? (pll_i & ~p_prev_q) : (xtal_i & ~x_prev_q);
    cur_lvl_w = act_src_q ? pll_i : xtal_i;
    stg_lvl_w = stg_src_i ? pll_i : xtal_i;
    wrap_w    = rise_w && (cnt_q == last_of(act_ratio_q, act_n_q));
    cnt_inc_w = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      x_prev_q    <= 1'b0;
      p_prev_q    <= 1'b0;
      act_src_q   <= 1'b0;
      act_ratio_q <= RATIO_1;
      act_n_q     <= '0;
      cnt_q       <= '0;
      lvl_q       <= 1'b0;
    end else begin
      x_prev_q <= xtal_i;
      p_prev_q <= pll_i;
      if (wrap_w) begin
        cnt_q       <= '0;
        act_src_q   <= stg_src_i;
        act_ratio_q <= stg_ratio_i;
        act_n_q     <= stg_n_i;
        if (is_hold(stg_ratio_i, stg_n_i)) lvl_q <= 1'b0;
        else if (stg_ratio_i == RATIO_1)   lvl_q <= stg_lvl_w;
        else                               lvl_q <= 1'b1;
      end else if (rise_w) begin
        cnt_q <= cnt_inc_w;
        lvl_q <= (cnt_inc_w < high_of(act_ratio_q, act_n_q));
      end else if (act_ratio_q == RATIO_1) begin
        lvl_q <= cur_lvl_w;
      end
    end
  end

  assign lvl_o = lvl_q;

  // R7: period counter never passes the end of its period
  p_cnt_in_period_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_of(act_ratio_q, act_n_q));

  // R7: the 2N waveform falls after exactly N source periods
  p_half_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio_q == RATIO_2N && rise_w && !wrap_w && cnt_inc_w == {1'b0, act_n_q}) |=> !lvl_q);

  // R10: committed settings move only at a period boundary
  p_commit_on_boundary_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_w |=> $stable({act_src_q, act_ratio_q, act_n_q}));

  // R8: zero divisor keeps the divided level low
  p_hold_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_hold(act_ratio_q, act_n_q) && !wrap_w) |=> !lvl_q);

  // R6: divide-by-3 is high for only the first source period
  p_div3_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio_q == RATIO_3 && rise_w && !wrap_w) |=> !lvl_q);

  // R5: divide-by-2 falls at the mid-period edge
  p_div2_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio_q == RATIO_2 && rise_w && cnt_q == '0) |=> !lvl_q);
endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W = CC_ADDR_W,
  parameter int DATA_W = CC_DATA_W,
  parameter int N_W    = CC_N_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xtal_i,
  input  logic              pll_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cpu_clk_o
);
  logic [N_W-1:0] div_n_w;
  ratio_e         ratio_w;
  logic           src_w, out_sel_w, div_lvl_w;
  logic           out_q;

  cpuclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .div_n_o   (div_n_w),
    .ratio_o   (ratio_w),
    .src_o     (src_w),
    .out_sel_o (out_sel_w)
  );

  cpuclk_div #(.N_W(N_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xtal_i      (xtal_i),
    .pll_i       (pll_i),
    .stg_src_i   (src_w),
    .stg_ratio_i (ratio_w),
    .stg_n_i     (div_n_w),
    .lvl_o       (div_lvl_w)
  );

  // output selector acts immediately so software can park on the crystal
  always_ff @(posedge clk_i) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_sel_w ? div_lvl_w : xtal_i;
  end

  assign cpu_clk_o = out_q;

  // R3: crystal bypass is a one-cycle copy
  p_xtal_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_sel_w |=> (cpu_clk_o == $past(xtal_i)));
endmodule

// File: tb/sim_cpuclk_gen.sv
`timescale 1ns/1ps
module sim_cpuclk_gen;
  localparam int XH = 4;   // crystal half period in clk cycles
  localparam int PH = 3;   // PLL half period in clk cycles
  localparam int LOGN = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xs = 1'b0, ps = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_clk;

  int n_tests = 0, n_fail = 0;
  int xc = 0, pc = 0, cd = 0;
  logic x_old = 1'b0, x_old2 = 1'b0, p_old = 1'b0, p_old2 = 1'b0;
  bit   mon_pll = 1'b0;
  bit   samp_log [LOGN];
  int   samp_cnt = 0;
  bit   exp_q [$];
  bit   sb_on = 1'b0, sb_lock = 1'b0, sb_last = 1'b0;
  string sb_tag = "";

  always #2.5 clk = ~clk;

  cpuclk_gen u0 (
    .clk_i (clk), .rst_ni (rst_n), .xtal_i (xs), .pll_i (ps),
    .reg_wr_i (reg_wr), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata), .cpu_clk_o (cpu_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // source generation and scoreboard monitor
  always @(negedge clk) begin
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        samp_cnt++;
        samp_log[samp_cnt % LOGN] = cpu_clk;
        if (sb_on) begin
          if (!sb_lock && cpu_clk && !sb_last) sb_lock = 1'b1;
          if (sb_lock && exp_q.size() > 0) begin
            chk(sb_tag, {31'd0, cpu_clk}, {31'd0, exp_q.pop_front()});
            if (exp_q.size() == 0) sb_on = 1'b0;
          end
        end
        sb_last = cpu_clk;
      end
    end
    x_old2 = x_old; x_old = xs;
    p_old2 = p_old; p_old = ps;
    xc++;
    if (xc == XH) begin
      xc = 0; xs = ~xs;
      if (xs && !mon_pll) cd = 3;
    end
    pc++;
    if (pc == PH) begin
      pc = 0; ps = ~ps;
      if (ps && mon_pll) cd = 3;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic follow(input string tag, input bit use_pll, input int lag, input int n);
    for (int i = 0; i < n; i++) begin
      logic e;
      @(negedge clk); #1;
      if (use_pll) e = (lag == 1) ? p_old : p_old2;
      else         e = (lag == 1) ? x_old : x_old2;
      chk(tag, {31'd0, cpu_clk}, {31'd0, e});
    end
  endtask

  // driver: push one expected waveform, monitor aligns on a rising sample
  task automatic expect_wave(input string tag, input int hi, input int lo, input int periods);
    int guard;
    exp_q.delete();
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < hi; i++) exp_q.push_back(1'b1);
      for (int i = 0; i < lo; i++) exp_q.push_back(1'b0);
    end
    sb_tag = tag; sb_lock = 1'b0; sb_on = 1'b1;
    guard = 0;
    while (sb_on && guard < 4000) begin @(negedge clk); guard++; end
    if (sb_on) begin
      sb_on = 1'b0; exp_q.delete();
      chk({tag, " timeout"}, 32'd0, 32'd1);
    end
  endtask

  task automatic settle();
    repeat (160) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    bit pat [6];
    repeat (6) @(negedge clk);
    #1 chk("R1 output low in reset", {31'd0, cpu_clk}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 divisor reg reset", 8'h00, 32'd0);
    rd_chk("R1 control reg reset", 8'h40, 32'd0);
    follow("R1 R3 crystal bypass after reset", 1'b0, 1, 32);

    // R2 read-back of every bit, R11 unmapped address
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h40, 32'h1234_5670);
    rd_chk("R2 divisor readback", 8'h00, 32'hDEAD_BEEF);
    rd_chk("R2 control readback", 8'h40, 32'h1234_5670);
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped reads 0", 8'h20, 32'd0);
    rd_chk("R11 divisor untouched", 8'h00, 32'hDEAD_BEEF);
    rd_chk("R11 control untouched", 8'h40, 32'h1234_5670);
    follow("R3 bypass kept after writes", 1'b0, 1, 24);
    wr(8'h00, 32'd0);

    // R4 ratio 1 from crystal, R9 ratio 1 from PLL
    wr(8'h40, 32'h0000_0080); settle();
    follow("R4 ratio 1 crystal", 1'b0, 2, 40);
    wr(8'h40, 32'h0000_0081); settle();
    follow("R4 R9 ratio 1 pll", 1'b1, 2, 40);

    // R5 ratio 2 crystal, R9 ratio 2 on PLL
    wr(8'h40, 32'h0000_0084); mon_pll = 1'b0; settle();
    expect_wave("R5 ratio 2 crystal", 1, 1, 4);
    wr(8'h40, 32'h0000_0085); mon_pll = 1'b1; settle();
    expect_wave("R9 ratio 2 pll", 1, 1, 4);
    wr(8'h40, 32'h0000_0084); settle(); mon_pll = 1'b0; settle();

    // R6 ratio 3
    wr(8'h40, 32'h0000_0088); settle();
    expect_wave("R6 ratio 3", 1, 2, 3);

    // R7 ratio 2N with several N
    wr(8'h00, 32'd3 << 20); wr(8'h40, 32'h0000_008C); settle();
    expect_wave("R7 2N with N=3", 3, 3, 2);
    wr(8'h00, 32'd1 << 20); settle();
    expect_wave("R7 2N with N=1", 1, 1, 3);
    wr(8'h00, 32'd5 << 20); settle(); settle();
    expect_wave("R7 2N with N=5", 5, 5, 1);

    // R8 zero divisor holds low, then exits
    wr(8'h00, 32'd0); settle(); settle();
    base = samp_cnt;
    while (samp_cnt < base + 8) @(negedge clk);
    for (int i = 1; i <= 8; i++)
      chk("R8 hold low with N=0", {31'd0, samp_log[(base + i) % LOGN]}, 32'd0);
    wr(8'h00, 32'd2 << 20); settle();
    expect_wave("R8 leaves hold with N=2", 2, 2, 2);

    // R10 change mid-period: divide-by-3 finishes before 2N(N=2) starts
    wr(8'h40, 32'h0000_0088); settle();
    do begin
      @(negedge clk); #1;
    end while (!(samp_cnt >= 2 && samp_log[samp_cnt % LOGN] == 1'b0 &&
                 samp_log[(samp_cnt - 1) % LOGN] == 1'b1));
    base = samp_cnt;
    wr(8'h40, 32'h0000_008C);
    while (samp_cnt < base + 6) @(negedge clk);
    pat = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    for (int i = 0; i < 6; i++)
      chk("R10 boundary commit", {31'd0, samp_log[(base + 1 + i) % LOGN]}, {31'd0, pat[i]});

    // R3 bypass acts at once from a divided mode
    wr(8'h40, 32'h0000_000C);
    follow("R3 bypass switch", 1'b0, 1, 32);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule